// File: doc/BRIEF.md
# Word-Packed SPI Byte Buffer

This block sits between a 32-bit host register port and a byte-serial SPI shifter. It keeps two independent byte stores of up to 32 bytes each. On the transmit side the host writes whole 32-bit words, and the shifter takes bytes one at a time. On the receive side the shifter deposits bytes one at a time, and the host collects them as whole 32-bit words. Inside every word, byte k of a transfer sits in lane k mod 4, so lane 0 (bits 7:0) comes first.

The shifter always moves bit 7 of the byte it is handed first. Each direction has its own bit-order setting. It defaults to MSB first, and when cleared it mirrors the bits of each byte between the store and the shifter. The host sees how full each side is, so it can tell how many lanes of the last receive word hold data. A clear strobe empties both sides. Two sticky flags record refused transmit writes and receive reads from an empty store.

Each side is run by a three-state occupancy machine:
- Transmit states: TX_EMPTY, TX_PART and TX_FULL. TX_FULL means fewer than four free bytes.
- Receive states: RX_EMPTY, RX_PART and RX_FULL. RX_FULL means 32 bytes are held.

Transitions are taken on the next fill level:
- load: EMPTY to PART or FULL.
- drain: PART or FULL to EMPTY.
- fill-up: PART to FULL.
- relieve: FULL to PART.
- Clear forces EMPTY from any state.

Top module: `spibuf_top`

## Requirements
- R1: After reset both fill levels are 0, both flags are 0, `tx_vld` is 0, `host_rdata` is 0, and both bit-order settings are MSB first (1).
- R2: An accepted word write makes its four bytes available to the shifter in lane order: bits 7:0 first, then 15:8, 23:16 and 31:24. `tx_vld` is 1 exactly when `tx_fill` is nonzero, and a `tx_pop` while `tx_vld` is 0 has no effect.
- R3: `tx_fill` rises by 4 for each accepted word write and falls by 1 for each accepted pop. A write and a pop in the same cycle give a net change of +3.
- R4: A word write is refused while `tx_fill` is above 28. A refused write leaves the fill and contents unchanged and sets `tx_ovf`, which stays set until a clear.
- R5: Received bytes are packed into lanes in arrival order. A read while `rx_fill` is 4 or more returns the next four bytes and lowers `rx_fill` by 4.
- R6: A read while `rx_fill` is 1 to 3 returns those bytes in the low lanes, with zeros in the other lanes, and leaves `rx_fill` at 0. The next received byte lands in lane 0 of a fresh word.
- R7: A read while `rx_fill` is 0 returns 0, leaves the fill at 0 and sets `rx_udf`, which stays set until a clear.
- R8: A received byte that arrives while `rx_fill` is 32 is dropped. The fill stays 32 and the held bytes are unchanged.
- R9: `cfg_we` loads the two bit-order settings (1 = MSB first). With the transmit setting at 0, every byte is bit-mirrored on `tx_byte` when it is presented. With the receive setting at 0, every byte is bit-mirrored when it is captured.
- R10: `clr` empties both sides and clears both flags. It takes priority over any write, read, pop or push in the same cycle.
- R11: A host read and a byte capture in the same cycle are handled as read first, then capture. The read returns only bytes held before that cycle. The new byte follows them, starting a fresh word if the read was partial. Fullness for the capture is judged on the fill before the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empties both sides and clears the flags |
| cfg_we | input | 1 | Loads the two bit-order settings |
| cfg_tx_msb | input | 1 | Transmit bit order to load (1 = MSB first) |
| cfg_rx_msb | input | 1 | Receive bit order to load (1 = MSB first) |
| host_wr | input | 1 | Host word write to the transmit side |
| host_wdata | input | 32 | Word written, lane 0 = bits 7:0 |
| host_rd | input | 1 | Host word read from the receive side, consumes the word |
| host_rdata | output | 32 | Word the next read returns, empty lanes zero |
| tx_pop | input | 1 | Shifter takes the presented byte |
| tx_byte | output | 8 | Byte presented to the shifter, sent bit 7 first |
| tx_vld | output | 1 | A transmit byte is available |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte, first bit in bit 7 |
| tx_fill | output | 6 | Transmit bytes held |
| rx_fill | output | 6 | Receive bytes held |
| tx_ovf | output | 1 | Sticky: a transmit write was refused |
| rx_udf | output | 1 | Sticky: a read found the receive side empty |

## Verification
On the receive side, a byte capture can meet a host read in the same cycle. The bench forces this while one to three bytes are held, which moves the capture into lane 0 of a new word. It also forces it while five bytes are held, so the capture simply appends. A scoreboard applies the read before the capture and compares both the returned word and the following read. On the transmit side, a word load can meet a byte pop in the same cycle. The bench drives both strobes together and checks the resulting fill and the byte order of the later drain.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;

    typedef enum logic [1:0] {
        TX_EMPTY = 2'd0,
        TX_PART  = 2'd1,
        TX_FULL  = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_EMPTY = 2'd0,
        RX_PART  = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_e;

    // Mirror the bit order inside one byte.
    function automatic logic [7:0] flip_byte(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) begin
            r[k] = b[7-k];
        end
        return r;
    endfunction

endpackage

// File: rtl/spibuf_tx.sv
module spibuf_tx
    import spibuf_pkg::*;
#(
    parameter int DEPTH_BYTES = 32,
    parameter int LANES       = 4,
    localparam int PW = $clog2(DEPTH_BYTES),
    localparam int CW = PW + 1,
    localparam int WW = LANES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_word,
    input  logic          msb_first,
    input  logic          pop,
    output logic [7:0]    byte_out,
    output logic          byte_vld,
    output logic [CW-1:0] fill,
    output logic          ovf
);

    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH_BYTES - LANES);
    localparam logic [CW-1:0] STEP    = CW'(LANES);

    tx_state_e     st_q, st_d;
    logic [CW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] fill_now, fill_nxt;
    logic          take_word, take_byte;
    logic [7:0]    mem_q [DEPTH_BYTES];
    logic [7:0]    head;

    always_comb begin
        fill_now  = wptr_q - rptr_q;
        take_word = wr_en && (st_q != TX_FULL);
        take_byte = pop && (st_q != TX_EMPTY);
        fill_nxt  = fill_now + (take_word ? STEP : '0) - (take_byte ? CW'(1) : '0);
    end

    // Next-state logic: load, drain, fill-up, relieve.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_EMPTY: begin
                if (take_word) begin
                    st_d = (fill_nxt > FULL_AT) ? TX_FULL : TX_PART;
                end
            end
            TX_PART: begin
                if (fill_nxt == '0) begin
                    st_d = TX_EMPTY;
                end else if (fill_nxt > FULL_AT) begin
                    st_d = TX_FULL;
                end
            end
            TX_FULL: begin
                if (fill_nxt == '0) begin
                    st_d = TX_EMPTY;
                end else if (fill_nxt <= FULL_AT) begin
                    st_d = TX_PART;
                end
            end
            default: st_d = TX_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TX_EMPTY;
        end else if (clr) begin
            st_q <= TX_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            ovf    <= 1'b0;
        end else begin
            if (take_word) begin
                wptr_q <= wptr_q + STEP;
            end
            if (take_byte) begin
                rptr_q <= rptr_q + CW'(1);
            end
            if (wr_en && (st_q == TX_FULL)) begin
                ovf <= 1'b1;
            end
        end
    end

    // Byte store: a word fills LANES consecutive slots, lane 0 first.
    always_ff @(posedge clk) begin
        if (take_word && !clr) begin
            for (int l = 0; l < LANES; l++) begin
                mem_q[wptr_q[PW-1:0] + PW'(l)] <= wr_word[l*8 +: 8];
            end
        end
    end

    // Outputs.
    always_comb begin
        head     = mem_q[rptr_q[PW-1:0]];
        byte_vld = (st_q != TX_EMPTY);
        byte_out = msb_first ? head : flip_byte(head);
        fill     = fill_now;
    end

endmodule

// File: rtl/spibuf_rx.sv
module spibuf_rx
    import spibuf_pkg::*;
#(
    parameter int DEPTH_BYTES = 32,
    parameter int LANES       = 4,
    localparam int PW = $clog2(DEPTH_BYTES),
    localparam int CW = PW + 1,
    localparam int WW = LANES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          msb_first,
    input  logic          rd_en,
    output logic [WW-1:0] rd_word,
    output logic [CW-1:0] fill,
    output logic          udf
);

    localparam logic [CW-1:0] CAP  = CW'(DEPTH_BYTES);
    localparam logic [CW-1:0] STEP = CW'(LANES);

    rx_state_e     st_q, st_d;
    logic [CW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] fill_now, fill_nxt;
    logic [CW-1:0] rptr_d, wbase, wptr_d;
    logic          take_rd, take_push, short_word;
    logic [7:0]    captured;
    logic [7:0]    mem_q [DEPTH_BYTES];

    // Read is applied first; a short read realigns the write slot to
    // the next word so the capture starts at lane 0.
    always_comb begin
        fill_now   = wptr_q - rptr_q;
        short_word = (fill_now < STEP);
        take_rd    = rd_en && (st_q != RX_EMPTY);
        take_push  = push && (st_q != RX_FULL);
        rptr_d     = take_rd ? (rptr_q + STEP) : rptr_q;
        wbase      = (take_rd && short_word) ? (rptr_q + STEP) : wptr_q;
        wptr_d     = take_push ? (wbase + CW'(1)) : wbase;
        fill_nxt   = wptr_d - rptr_d;
        captured   = msb_first ? push_byte : flip_byte(push_byte);
    end

    // Next-state logic: load, drain, fill-up, relieve.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_EMPTY: begin
                if (take_push) begin
                    st_d = (fill_nxt == CAP) ? RX_FULL : RX_PART;
                end
            end
            RX_PART: begin
                if (fill_nxt == '0) begin
                    st_d = RX_EMPTY;
                end else if (fill_nxt == CAP) begin
                    st_d = RX_FULL;
                end
            end
            RX_FULL: begin
                if (fill_nxt == '0) begin
                    st_d = RX_EMPTY;
                end else if (fill_nxt != CAP) begin
                    st_d = RX_PART;
                end
            end
            default: st_d = RX_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RX_EMPTY;
        end else if (clr) begin
            st_q <= RX_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            udf    <= 1'b0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            udf    <= 1'b0;
        end else begin
            wptr_q <= wptr_d;
            rptr_q <= rptr_d;
            if (rd_en && (st_q == RX_EMPTY)) begin
                udf <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take_push && !clr) begin
            mem_q[wbase[PW-1:0]] <= captured;
        end
    end

    // Outputs: lanes beyond the held count read as zero.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_word[l*8 +: 8] = (CW'(l) < fill_now) ? mem_q[rptr_q[PW-1:0] + PW'(l)] : 8'h00;
        end
        fill = fill_now;
    end

endmodule

// File: rtl/spibuf_top.sv
module spibuf_top
    import spibuf_pkg::*;
#(
    parameter int DEPTH_BYTES = 32,
    parameter int LANES       = 4,
    localparam int PW = $clog2(DEPTH_BYTES),
    localparam int CW = PW + 1,
    localparam int WW = LANES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cfg_we,
    input  logic          cfg_tx_msb,
    input  logic          cfg_rx_msb,
    input  logic          host_wr,
    input  logic [WW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [WW-1:0] host_rdata,
    input  logic          tx_pop,
    output logic [7:0]    tx_byte,
    output logic          tx_vld,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    output logic [CW-1:0] tx_fill,
    output logic [CW-1:0] rx_fill,
    output logic          tx_ovf,
    output logic          rx_udf
);

    logic tx_msb_q, rx_msb_q;

    // Bit-order settings, MSB first out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_msb_q <= 1'b1;
            rx_msb_q <= 1'b1;
        end else if (cfg_we) begin
            tx_msb_q <= cfg_tx_msb;
            rx_msb_q <= cfg_rx_msb;
        end
    end

    spibuf_tx #(
        .DEPTH_BYTES(DEPTH_BYTES),
        .LANES      (LANES)
    ) tx_side_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_en    (host_wr),
        .wr_word  (host_wdata),
        .msb_first(tx_msb_q),
        .pop      (tx_pop),
        .byte_out (tx_byte),
        .byte_vld (tx_vld),
        .fill     (tx_fill),
        .ovf      (tx_ovf)
    );

    spibuf_rx #(
        .DEPTH_BYTES(DEPTH_BYTES),
        .LANES      (LANES)
    ) rx_side_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .push     (rx_push),
        .push_byte(rx_byte),
        .msb_first(rx_msb_q),
        .rd_en    (host_rd),
        .rd_word  (host_rdata),
        .fill     (rx_fill),
        .udf      (rx_udf)
    );

endmodule

// File: rtl/spibuf_chk.sv
module spibuf_chk #(
    parameter int DEPTH_BYTES = 32,
    parameter int LANES       = 4,
    localparam int PW = $clog2(DEPTH_BYTES),
    localparam int CW = PW + 1,
    localparam int WW = LANES * 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          host_wr,
    input logic          host_rd,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          tx_vld,
    input logic [CW-1:0] tx_fill,
    input logic [CW-1:0] rx_fill,
    input logic          tx_ovf,
    input logic          rx_udf,
    input logic [WW-1:0] host_rdata
);

    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH_BYTES - LANES);
    localparam logic [CW-1:0] STEP    = CW'(LANES);
    localparam logic [CW-1:0] CAP     = CW'(DEPTH_BYTES);

    // R2
    tx_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld == (tx_fill != '0));

    // R3
    tx_fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && host_wr && !tx_pop && tx_fill <= FULL_AT) |=> (tx_fill == $past(tx_fill) + STEP));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && host_wr && !tx_pop && tx_fill > FULL_AT) |=> (tx_ovf && $stable(tx_fill)));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !clr) |=> tx_ovf);

    // R6
    rx_lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rx_fill < STEP) |-> ((host_rdata >> (32'(rx_fill) * 8)) == '0));

    // R7
    rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && host_rd && !rx_push && rx_fill == '0) |=> (rx_udf && rx_fill == '0));

    // R8
    rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fill <= CAP);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tx_fill == '0 && rx_fill == '0 && !tx_ovf && !rx_udf));

endmodule

bind spibuf_top spibuf_chk #(
    .DEPTH_BYTES(DEPTH_BYTES),
    .LANES      (LANES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .tx_vld    (tx_vld),
    .tx_fill   (tx_fill),
    .rx_fill   (rx_fill),
    .tx_ovf    (tx_ovf),
    .rx_udf    (rx_udf),
    .host_rdata(host_rdata)
);

// File: tb/spibuf_top_tb_top.sv
`timescale 1ns/1ps
module spibuf_top_tb_top;

    localparam int DEPTH = 32;
    localparam int LANES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, cfg_we = 1'b0, cfg_tx_msb = 1'b1, cfg_rx_msb = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] host_rdata;
    logic [7:0]  tx_byte;
    logic        tx_vld, tx_ovf, rx_udf;
    logic [5:0]  tx_fill, rx_fill;

    always #2.5 clk = ~clk;

    spibuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we),
        .cfg_tx_msb(cfg_tx_msb), .cfg_rx_msb(cfg_rx_msb),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_vld(tx_vld),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_fill(tx_fill), .rx_fill(rx_fill),
        .tx_ovf(tx_ovf), .rx_udf(rx_udf)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Scoreboard state.
    logic [7:0]  tx_q[$];
    logic [7:0]  rx_q[$];
    bit          tx_pend = 0, rx_pend = 0;
    logic [31:0] tx_pend_word;
    logic [7:0]  rx_pend_byte;
    bit          exp_tx_ovf = 0, exp_rx_udf = 0;
    bit          m_tx_msb = 1, m_rx_msb = 1;

    function automatic logic [7:0] mirror(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        host_wr = 0; host_rd = 0; tx_pop = 0; rx_push = 0; clr = 0; cfg_we = 0;
    endtask

    // Driver tasks: they set strobes and push expected items.
    task automatic drv_write(input logic [31:0] w);
        host_wr = 1; host_wdata = w;
        if (tx_q.size() > DEPTH - LANES) exp_tx_ovf = 1;
        else begin tx_pend = 1; tx_pend_word = w; end
    endtask

    task automatic drv_push(input logic [7:0] b);
        rx_push = 1; rx_byte = b;
        if (rx_q.size() < DEPTH) begin
            rx_pend = 1;
            rx_pend_byte = m_rx_msb ? b : mirror(b);
        end
    endtask

    task automatic drv_pop();  tx_pop = 1;  endtask
    task automatic drv_read(); host_rd = 1; endtask

    task automatic drv_clear();
        clr = 1;
    endtask

    task automatic drv_cfg(input bit t, input bit r);
        cfg_we = 1; cfg_tx_msb = t; cfg_rx_msb = r;
        step();
        m_tx_msb = t; m_rx_msb = r;
    endtask

    // Monitor: compares outputs with the scoreboard away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (clr) begin
                tx_q.delete(); rx_q.delete();
                tx_pend = 0; rx_pend = 0;
                exp_tx_ovf = 0; exp_rx_udf = 0;
            end else begin
                if (tx_pop) begin
                    if (tx_q.size() == 0) begin
                        chk(tx_vld == 1'b0, "R2 pop while empty", {31'b0, tx_vld}, 32'h0);
                    end else begin
                        logic [7:0] e;
                        e = tx_q.pop_front();
                        if (!m_tx_msb) e = mirror(e);
                        chk(tx_byte == e && tx_vld, "R2/R9 tx byte", {24'b0, tx_byte}, {24'b0, e});
                    end
                end
                if (tx_pend) begin
                    for (int l = 0; l < LANES; l++) tx_q.push_back(tx_pend_word[l*8 +: 8]);
                    tx_pend = 0;
                end
                if (host_rd) begin
                    logic [31:0] ew;
                    int n;
                    ew = '0;
                    n = (rx_q.size() < LANES) ? rx_q.size() : LANES;
                    if (n == 0) exp_rx_udf = 1;
                    for (int l = 0; l < n; l++) ew[l*8 +: 8] = rx_q.pop_front();
                    chk(host_rdata == ew, "R5/R6/R7/R11 rx word", host_rdata, ew);
                end
                if (rx_pend) begin
                    rx_q.push_back(rx_pend_byte);
                    rx_pend = 0;
                end
            end
        end
    end

    task automatic check_fills(input string req);
        chk(tx_fill == 6'(tx_q.size()), {req, " tx_fill"}, {26'b0, tx_fill}, tx_q.size());
        chk(rx_fill == 6'(rx_q.size()), {req, " rx_fill"}, {26'b0, rx_fill}, rx_q.size());
        chk(tx_ovf == exp_tx_ovf, {req, " tx_ovf"}, {31'b0, tx_ovf}, {31'b0, exp_tx_ovf});
        chk(rx_udf == exp_rx_udf, {req, " rx_udf"}, {31'b0, rx_udf}, {31'b0, exp_rx_udf});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        check_fills("R1");
        chk(tx_vld == 0, "R1 tx_vld", {31'b0, tx_vld}, 0);
        chk(host_rdata == 0, "R1 host_rdata", host_rdata, 0);

        // R2 lane order, R1 default MSB first
        drv_write(32'h44332211); step();
        check_fills("R2");
        chk(tx_vld == 1, "R2 tx_vld", {31'b0, tx_vld}, 1);
        repeat (4) begin drv_pop(); step(); end
        check_fills("R2 drained");
        drv_pop(); step();              // R2 pop while empty ignored
        check_fills("R2 empty pop");

        // R3 write and pop in one cycle
        drv_write(32'hA3A2A1A0); step();
        drv_write(32'hB3B2B1B0); step();
        drv_write(32'hC3C2C1C0); drv_pop(); step();
        chk(tx_fill == 6'd11, "R3 concurrent net +3", {26'b0, tx_fill}, 11);
        repeat (11) begin drv_pop(); step(); end
        check_fills("R3 drained");

        // R4 overflow
        for (int i = 0; i < 8; i++) begin drv_write({4{8'(8'h10 + i)}} ^ 32'h00FF0000); step(); end
        chk(tx_fill == 6'd32, "R4 full", {26'b0, tx_fill}, 32);
        drv_write(32'hDEADBEEF); step();
        check_fills("R4 refused at 32");
        repeat (3) begin drv_pop(); step(); end
        drv_write(32'hDEADBEEF); step();
        check_fills("R4 refused at 29");
        repeat (29) begin drv_pop(); step(); end
        check_fills("R4 sticky after drain");

        // R10 clear with a concurrent write
        drv_clear(); drv_write(32'h01020304); step();
        check_fills("R10 clear");

        // R9 transmit mirroring
        drv_cfg(1'b0, 1'b1);
        drv_write(32'h8001C003); step();
        repeat (4) begin drv_pop(); step(); end
        drv_cfg(1'b1, 1'b1);

        // R5 / R6 receive packing and partial word
        for (int i = 0; i < 6; i++) begin drv_push(8'(8'hA1 + i)); step(); end
        check_fills("R5 six bytes");
        drv_read(); step();
        check_fills("R5 after full read");
        drv_read(); step();
        check_fills("R6 after partial read");
        drv_push(8'hB1); step();
        drv_read(); step();

        // R7 underflow
        drv_read(); step();
        check_fills("R7 underflow");

        // R11 same-cycle read and capture
        drv_push(8'hC1); step();
        drv_push(8'hC2); step();
        drv_read(); drv_push(8'hC3); step();
        check_fills("R11 partial read with push");
        drv_read(); step();
        for (int i = 0; i < 5; i++) begin drv_push(8'(8'hD0 + i)); step(); end
        drv_read(); drv_push(8'hD5); step();
        check_fills("R11 full read with push");
        repeat (2) begin drv_read(); step(); end
        check_fills("R11 drained");

        // R8 receive full
        drv_clear(); step();
        for (int i = 0; i < 33; i++) begin drv_push(8'(8'h40 + i)); step(); end
        check_fills("R8 full and dropped");
        repeat (8) begin drv_read(); step(); end
        check_fills("R8 drained");

        // R9 receive mirroring
        drv_cfg(1'b1, 1'b0);
        drv_push(8'h01); step();
        drv_push(8'h0F); step();
        drv_read(); step();
        drv_cfg(1'b1, 1'b1);

        // R10 clear over receive activity
        drv_push(8'h77); step();
        drv_clear(); drv_push(8'h78); drv_read(); step();
        check_fills("R10 clear priority");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule